// File: doc/BRIEF.md
# Handshaked Serial Event-Report Transmitter

This block is the slave end of a two-wire synchronous link. It hands one decoded event to a host controller. The host drives the clock line and the block drives the data line.

When an event record is strobed in while the block is idle, the block raises the data line to request service. It keeps the line high until the host acknowledges by raising the clock. The request is given up if the bounded request window runs out first. After the acknowledge, the block pulls the data line low. On every later falling edge of the host clock it presents the next bit of an 80-bit report, least significant bit first. The host therefore reads each bit while the clock is high.

The host can stop the transfer after any number of bits by holding its clock low. When the low time exceeds a limit, the block goes back to idle and pulses a done flag. Both time limits are counted in units of an external tick. The host clock is passed through a two-flop synchronizer before its edges are detected.

Top module: `evt_report_tx`

## Requirements
- R1: When `evt_valid` is high while the block is idle, `data_out` and `busy` are both high on the next cycle.
- R2: While a request is pending, a rising host clock (seen after the synchronizer) drives `data_out` low. No report bit is presented before the next falling host clock edge.
- R3: Report bit positions, in shift order from bit 0: bit 0 is a constant 0; bit 1 is `evt_repeat`; bit 2 is `evt_lowbat`; bits 3..6 are `evt_func[0..3]`; bit 7 is a constant 1; bits 8..11 are `evt_block[0..3]`; bits 12..15 are `evt_count[0..3]`; bits 16..79 are `evt_payload[0..63]`.
- R4: Report bit k is placed on `data_out` three `clk` cycles after the (k+1)-th falling edge of `host_clk` that follows the acknowledge. It then holds until the next falling edge is seen.
- R5: During a report, when `host_clk` has stayed low for `IDLE_TICKS` ticks, the block returns to idle with `data_out` low. `done` is high for exactly one cycle at that point.
- R6: At most 80 report bits are presented. Any falling edge after the 80th bit leaves `data_out` low.
- R7: If no acknowledge arrives within `REQ_TICKS` ticks of the request, the block drops `data_out`, clears `busy` and discards the report. `done` is not raised.
- R8: An `evt_valid` pulse while `busy` is high is ignored. The report in progress continues unchanged.
- R9: After reset, `data_out`, `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timebase pulse, one `clk` cycle wide |
| evt_valid | input | 1 | Strobe for the event record |
| evt_repeat | input | 1 | Repeat status flag |
| evt_lowbat | input | 1 | Low-voltage status flag |
| evt_func | input | 4 | Function code |
| evt_block | input | 4 | Index of the block used |
| evt_count | input | 4 | Number of learned transmitters |
| evt_payload | input | PAYLOAD_W | Decrypted payload |
| host_clk | input | 1 | Clock line driven by the host |
| data_out | output | 1 | Data line drive |
| busy | output | 1 | A request or report is in progress |
| done | output | 1 | One-cycle pulse when a report ends on the clock-low timeout |

## Verification
The bench runs three patterns.

The first is a full transfer with three extra clocks after the last bit. It separates correct field placement and bit order from off-by-one shifting, and it shows that the line stays quiet after 80 bits. The second is an event that the host never acknowledges. It isolates expiry of the request window from the clock-low timeout, since it must end without a `done` pulse. The third is a short transfer that the host abandons after twelve bits, with a second, different event strobed in partway through. It shows that an early abort ends cleanly and that the late event leaves the bits being shifted untouched.

A behavioural model runs beside the design and is compared on every cycle. It pins down the synchronizer latency and which edge each bit follows.

// File: rtl/evt_report_tx.sv
module evt_report_tx #(
  parameter int PAYLOAD_W  = 64,
  parameter int REQ_TICKS  = 5000,
  parameter int IDLE_TICKS = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 evt_valid,
  input  logic                 evt_repeat,
  input  logic                 evt_lowbat,
  input  logic [3:0]           evt_func,
  input  logic [3:0]           evt_block,
  input  logic [3:0]           evt_count,
  input  logic [PAYLOAD_W-1:0] evt_payload,
  input  logic                 host_clk,
  output logic                 data_out,
  output logic                 busy,
  output logic                 done
);
  localparam int REPORT_W = PAYLOAD_W + 16;
  localparam int BIT_W    = $clog2(REPORT_W + 1);
  localparam int REQ_W    = $clog2(REQ_TICKS + 1);
  localparam int IDLE_W   = $clog2(IDLE_TICKS + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_ACK, ST_SHIFT} st_t;

  st_t                 state;
  logic [REPORT_W-1:0] sr;
  logic [BIT_W-1:0]    nbits;
  logic [REQ_W-1:0]    req_cnt;
  logic [IDLE_W-1:0]   low_cnt;
  logic                s1, s2, s3;
  logic                data_q, done_q;

  wire rise   = s2 & ~s3;
  wire fall   = ~s2 & s3;
  wire in_rep = (state == ST_ACK) || (state == ST_SHIFT);
  wire low_to = in_rep & ~s2 & tick & (low_cnt == IDLE_W'(IDLE_TICKS - 1));
  wire req_to = (state == ST_REQ) & ~rise & tick & (req_cnt == REQ_W'(REQ_TICKS - 1));

  assign data_out = data_q;
  assign busy     = (state != ST_IDLE);
  assign done     = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      sr      <= '0;
      nbits   <= '0;
      req_cnt <= '0;
      low_cnt <= '0;
      s1      <= 1'b0;
      s2      <= 1'b0;
      s3      <= 1'b0;
      data_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      s1     <= host_clk;
      s2     <= s1;
      s3     <= s2;
      done_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (evt_valid) begin
            sr      <= {evt_payload, evt_count, evt_block, 1'b1, evt_func,
                        evt_lowbat, evt_repeat, 1'b0};
            nbits   <= '0;
            req_cnt <= '0;
            data_q  <= 1'b1;
            state   <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (rise) begin
            data_q  <= 1'b0;
            low_cnt <= '0;
            state   <= ST_ACK;
          end else if (req_to) begin
            data_q <= 1'b0;
            state  <= ST_IDLE;
          end else if (tick) begin
            req_cnt <= req_cnt + 1'b1;
          end
        end
        default: begin
          if (low_to) begin
            data_q <= 1'b0;
            done_q <= 1'b1;
            state  <= ST_IDLE;
          end else begin
            if (s2)        low_cnt <= '0;
            else if (tick) low_cnt <= low_cnt + 1'b1;
            if (fall) begin
              state <= ST_SHIFT;
              if (nbits < BIT_W'(REPORT_W)) begin
                data_q <= sr[0];
                sr     <= sr >> 1;
                nbits  <= nbits + 1'b1;
              end else begin
                data_q <= 1'b0;
              end
            end
          end
        end
      endcase
    end
  end

  AST_REQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && evt_valid) |=> (data_out && busy)); // R1
  AST_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_REQ && rise) |=> (!data_out && state == ST_ACK)); // R2
  AST_HOLD_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SHIFT && !fall && !low_to) |=> $stable(data_out)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !data_out)); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5
  AST_BIT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    nbits <= BIT_W'(REPORT_W)); // R6
  AST_REQ_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    req_to |=> (!busy && !done && !data_out)); // R7
  AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && evt_valid && !fall) |=> $stable(sr)); // R8
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !data_out); // R9
endmodule

// File: tb/evt_report_tx_tb.sv
module evt_report_tx_tb_top;
  localparam int PW = 64, RT = 6, IT = 4, TDIV = 8, HALF = 6, RW = PW + 16;

  logic clk = 0, rst_n = 0, tick = 0, evt_valid = 0, host_clk = 0;
  logic evt_repeat = 0, evt_lowbat = 0;
  logic [3:0] evt_func = 0, evt_block = 0, evt_count = 0;
  logic [PW-1:0] evt_payload = 0;
  logic data_out, busy, done;

  int checks = 0, fails = 0, tdiv = 0, done_seen = 0;
  string tag = "R9";
  logic rx [0:127];

  // behavioural reference state
  int mstate = 0, mbits = 0, mreq = 0, mlow = 0, mh1 = 0, mh2 = 0, mh3 = 0;
  logic ed = 0, edn = 0;
  logic [RW-1:0] mrep = 0;

  always #5 clk = ~clk;

  evt_report_tx #(.PAYLOAD_W(PW), .REQ_TICKS(RT), .IDLE_TICKS(IT)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .evt_valid(evt_valid),
    .evt_repeat(evt_repeat), .evt_lowbat(evt_lowbat), .evt_func(evt_func),
    .evt_block(evt_block), .evt_count(evt_count), .evt_payload(evt_payload),
    .host_clk(host_clk), .data_out(data_out), .busy(busy), .done(done));

  function automatic logic [RW-1:0] build(logic r, logic l, logic [3:0] f,
      logic [3:0] b, logic [3:0] c, logic [PW-1:0] p);
    logic [RW-1:0] v;
    v = '0;
    v[1] = r; v[2] = l; v[7] = 1'b1;
    for (int k = 0; k < 4; k++) begin
      v[3+k] = f[k]; v[8+k] = b[k]; v[12+k] = c[k];
    end
    for (int k = 0; k < PW; k++) v[16+k] = p[k];
    return v;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin tdiv = 0; tick = 0; end
    else begin tick = (tdiv == TDIV-1); tdiv = (tdiv + 1) % TDIV; end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      mstate = 0; mbits = 0; mreq = 0; mlow = 0; mh1 = 0; mh2 = 0; mh3 = 0;
      ed = 0; edn = 0;
    end else begin
      edn = 0;
      if (mstate == 0) begin
        if (evt_valid) begin
          mrep = build(evt_repeat, evt_lowbat, evt_func, evt_block, evt_count, evt_payload);
          mbits = 0; mreq = 0; ed = 1; mstate = 1;
        end
      end else if (mstate == 1) begin
        if (mh2 == 1 && mh3 == 0) begin ed = 0; mlow = 0; mstate = 2; end
        else if (tick) begin
          if (mreq == RT-1) begin ed = 0; mstate = 0; end
          else mreq++;
        end
      end else begin
        if (mh2 == 0 && tick && mlow == IT-1) begin
          ed = 0; edn = 1; mstate = 0;
        end else begin
          if (mh2 == 1) mlow = 0; else if (tick) mlow++;
          if (mh2 == 0 && mh3 == 1) begin
            mstate = 3;
            if (mbits < RW) begin ed = mrep[mbits]; mbits++; end
            else ed = 0;
          end
        end
      end
      mh3 = mh2; mh2 = mh1; mh1 = int'(host_clk);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (done) done_seen++;
      checks++;
      if (data_out !== ed || busy !== (mstate != 0) || done !== edn) begin
        fails++;
        $display("FAIL %s per-cycle: data %b exp %b, busy %b exp %b, done %b exp %b",
                 tag, data_out, ed, busy, mstate != 0, done, edn);
      end
    end
  end

  task automatic check(string t, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", t, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_event(logic r, logic l, logic [3:0] f, logic [3:0] b,
      logic [3:0] c, logic [PW-1:0] p);
    @(negedge clk);
    evt_repeat = r; evt_lowbat = l; evt_func = f; evt_block = b;
    evt_count = c; evt_payload = p; evt_valid = 1;
    @(negedge clk);
    evt_valid = 0;
  endtask

  task automatic clock_bits(int n, int inj);
    for (int i = 0; i < n; i++) begin
      host_clk = 0;
      wait_n(HALF);
      host_clk = 1;
      if (i == inj) begin
        evt_repeat = 0; evt_lowbat = 0; evt_func = 4'h0; evt_block = 4'h0;
        evt_count = 4'h0; evt_payload = '0; evt_valid = 1;
        @(negedge clk);
        evt_valid = 0;
        wait_n(HALF/2 - 1);
      end else wait_n(HALF/2);
      rx[i] = data_out;
      wait_n(HALF - HALF/2);
    end
    host_clk = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [RW-1:0] e1, e2;
    wait_n(3);
    tag = "R9";
    check("R9 reset data_out", data_out, 1'b0);
    check("R9 reset busy", busy, 1'b0);
    check("R9 reset done", done, 1'b0);
    rst_n = 1;
    wait_n(4);

    // Pattern 1: full report plus extra clocks, then clock-low timeout
    tag = "R3";
    e1 = build(1, 0, 4'b1010, 4'h3, 4'hC, 64'h0123_4567_89AB_CDEF);
    send_event(1, 0, 4'b1010, 4'h3, 4'hC, 64'h0123_4567_89AB_CDEF);
    check("R1 request raised", data_out, 1'b1);
    check("R1 busy raised", busy, 1'b1);
    wait_n(5);
    tag = "R2";
    host_clk = 1;
    wait_n(HALF);
    check("R2 data low after acknowledge", data_out, 1'b0);
    check("R2 still busy after acknowledge", busy, 1'b1);
    tag = "R4";
    clock_bits(RW + 3, -1);
    for (int i = 0; i < RW; i++) check($sformatf("R3 bit %0d", i), rx[i], e1[i]);
    for (int i = RW; i < RW + 3; i++) check($sformatf("R6 extra bit %0d", i), rx[i], 1'b0);
    tag = "R5";
    done_seen = 0;
    wait_n(IT * TDIV + 20);
    check("R5 idle after clock-low timeout", busy, 1'b0);
    check("R5 done pulsed once", done_seen == 1, 1'b1);

    // Pattern 2: request never acknowledged
    tag = "R7";
    done_seen = 0;
    send_event(0, 1, 4'h6, 4'h1, 4'h2, 64'hFFFF_0000_AAAA_5555);
    wait_n(RT * TDIV + 20);
    check("R7 busy cleared after window", busy, 1'b0);
    check("R7 data low after window", data_out, 1'b0);
    check("R7 no done on expiry", done_seen == 0, 1'b1);

    // Pattern 3: short report, late event ignored, host abort
    tag = "R8";
    done_seen = 0;
    e2 = build(0, 1, 4'h5, 4'hE, 4'h7, {PW{1'b1}});
    send_event(0, 1, 4'h5, 4'hE, 4'h7, {PW{1'b1}});
    wait_n(4);
    host_clk = 1;
    wait_n(HALF);
    clock_bits(12, 5);
    for (int i = 0; i < 12; i++) check($sformatf("R8 bit %0d after late event", i), rx[i], e2[i]);
    tag = "R5";
    wait_n(IT * TDIV + 20);
    check("R5 abort returns idle", busy, 1'b0);
    check("R5 abort done pulse", done_seen == 1, 1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule